// File: doc/BRIEF.md
# Network Interrupt Status Aggregator

This block gathers per-port interrupt events from up to seven network module slots and keeps them in two 32-bit status words. Each event names a slot and a port. The block turns that pair into one bit of one status word through a fixed slot map. The map depends on the chassis mode input. A set event raises the bit and a clear event lowers it. A read never changes any status bit.

A single level output, `netIrq`, tells the CPU that at least one relevant status bit is set. Software finds the source through a small read port. In the small chassis modes the port shows status word 0 one byte at a time, at four byte-lane addresses. In the large chassis mode each status word is read whole. A platform code is readable in every mode. Reads are combinational: `rdData` follows `rdEn` and `rdAddr` in the same cycle. Status changes become visible one clock edge after the event.

Top module: `nirq_aggregator`

## Requirements
- R1: After reset both status words are zero, `netIrq` is low, and every status read returns zero.
- R2: A set event for a mapped slot raises bit (slot base + port) of that slot's status word, on the clock edge that samples the event. No other bit changes.
- R3: A clear event for a mapped slot lowers bit (slot base + port) of that slot's status word, and no other bit changes.
- R4: `chassisMode` 0 is the four-slot small chassis. It maps slots 0, 1, 2 and 3 to word 0 with bases 16, 24, 0 and 8. `chassisMode` 1 is the two-slot small chassis. It maps only slot 0 (base 16) and slot 1 (base 24), both to word 0.
- R5: `chassisMode` 2 and 3 are the large chassis. Slot 0 maps to word 1 with base 0. Slots 1, 2, 3, 4, 5 and 6 map to word 0 with bases 24, 16, 28, 20, 8 and 0.
- R6: An event is ignored if its slot is unmapped in the current mode. It is also ignored if base + port exceeds 31.
- R7: When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: In modes 0 and 1, `netIrq` is high exactly while word 0 is nonzero. In modes 2 and 3 it is high while either word is nonzero. It follows the status words with no added delay.
- R9: In modes 0 and 1, a read returns word 0 bits 31:24, 23:16, 15:8 and 7:0, zero-extended, at addresses 0x20000, 0x20001, 0x20002 and 0x20003 respectively.
- R10: In modes 2 and 3, address 0x10010 returns all of word 0 and address 0x20010 returns all of word 1. The byte-lane addresses return zero in these modes, and the word addresses return zero in modes 0 and 1.
- R11: Reading a status address leaves every status bit unchanged.
- R12: Address 0x30000 returns the platform code: 0x00 in mode 0, 0x80 in mode 1, and 0x60 in modes 2 and 3. Any other address, and any cycle with `rdEn` low, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chassisMode | input | 2 | Chassis mode: 0 four-slot small, 1 two-slot small, 2/3 large |
| setValid | input | 1 | Set event strobe |
| setSlot | input | 3 | Slot of the set event |
| setPort | input | 5 | Port of the set event |
| clrValid | input | 1 | Clear event strobe |
| clrSlot | input | 3 | Slot of the clear event |
| clrPort | input | 5 | Port of the clear event |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 18 | Read address |
| rdData | output | 32 | Read data, combinational |
| netIrq | output | 1 | Combined network interrupt |

## Verification
The bench sweeps every mode, slot and port, eight slot codes by 32 ports. It sets one bit from an empty state, reads it back through the read port, then clears it again. A wrong base in the map would light the wrong bit. A missing bound check would fold out-of-range positions back into low bits instead of ignoring them. Further directed cases target these faults:
- A same-cycle set and clear of one bit; a clear-first update would drop the bit.
- Two reads in a row; a clear-on-read design would empty the status words.
- A mode switch while only word 1 holds a bit; `netIrq` must then fall in the small modes.
- The shuffled byte-lane order, the platform codes, and reads at unknown addresses.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

  localparam int STATUS_W = 32;
  localparam int BIT_W    = $clog2(STATUS_W);

  typedef enum logic [1:0] {
    CH_SMALL4 = 2'd0,
    CH_SMALL2 = 2'd1,
    CH_LARGE  = 2'd2,
    CH_LARGEB = 2'd3
  } chassisE;

  typedef enum logic [2:0] {
    RD_NONE, RD_LANE3, RD_LANE2, RD_LANE1, RD_LANE0, RD_WORD0, RD_WORD1, RD_PLAT
  } rdSelE;

  typedef struct packed {
    logic ok;
    logic regSel;
    logic [5:0] base;
  } slotMapT;

  typedef struct packed {
    logic             setEn;
    logic             setReg;
    logic [BIT_W-1:0] setBit;
    logic             clrEn;
    logic             clrReg;
    logic [BIT_W-1:0] clrBit;
    rdSelE            rdSel;
  } strobeT;

  function automatic logic isLarge(input chassisE mode);
    return (mode == CH_LARGE) || (mode == CH_LARGEB);
  endfunction

  // Slot map; the bases are fixed by the board wiring.
  function automatic slotMapT mapSlot(input chassisE mode, input logic [2:0] slot);
    slotMapT m;
    m = '0;
    if (isLarge(mode)) begin
      m.ok = 1'b1;
      case (slot)
        3'd0: begin m.regSel = 1'b1; m.base = 6'd0; end
        3'd1: m.base = 6'd24;
        3'd2: m.base = 6'd16;
        3'd3: m.base = 6'd28;
        3'd4: m.base = 6'd20;
        3'd5: m.base = 6'd8;
        3'd6: m.base = 6'd0;
        default: m.ok = 1'b0;
      endcase
    end else begin
      m.ok = (slot < 3'd2) || (mode == CH_SMALL4 && slot < 3'd4);
      case (slot)
        3'd0: m.base = 6'd16;
        3'd1: m.base = 6'd24;
        3'd2: m.base = 6'd0;
        3'd3: m.base = 6'd8;
        default: m.base = 6'd0;
      endcase
    end
    return m;
  endfunction

  function automatic logic [7:0] platformCode(input chassisE mode);
    case (mode)
      CH_SMALL4: return 8'h00;
      CH_SMALL2: return 8'h80;
      default:   return 8'h60;
    endcase
  endfunction

endpackage

// File: rtl/nirq_ctrl.sv
module nirq_ctrl
  import nirq_pkg::*;
#(
  parameter int SLOT_W = 3,
  parameter int PORT_W = 5,
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] LANE_ADDR  = 18'h20000,
  parameter logic [ADDR_W-1:0] WORD0_ADDR = 18'h10010,
  parameter logic [ADDR_W-1:0] WORD1_ADDR = 18'h20010,
  parameter logic [ADDR_W-1:0] PLAT_ADDR  = 18'h30000
) (
  input  logic              clk,
  input  logic              rstN,
  input  chassisE           mode,
  input  logic              setValid,
  input  logic [SLOT_W-1:0] setSlot,
  input  logic [PORT_W-1:0] setPort,
  input  logic              clrValid,
  input  logic [SLOT_W-1:0] clrSlot,
  input  logic [PORT_W-1:0] clrPort,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobeT            strb
);

  localparam int POS_W = ((PORT_W > 6) ? PORT_W : 6) + 1;

  slotMapT          setMap, clrMap;
  logic [POS_W-1:0] setPos, clrPos;

  always_comb begin
    setMap = mapSlot(mode, 3'(setSlot));
    clrMap = mapSlot(mode, 3'(clrSlot));
    setPos = POS_W'(setMap.base) + POS_W'(setPort);
    clrPos = POS_W'(clrMap.base) + POS_W'(clrPort);
  end

  always_comb begin
    strb.setEn  = setValid && setMap.ok && (setPos < POS_W'(STATUS_W));
    strb.setReg = setMap.regSel;
    strb.setBit = setPos[BIT_W-1:0];
    strb.clrEn  = clrValid && clrMap.ok && (clrPos < POS_W'(STATUS_W));
    strb.clrReg = clrMap.regSel;
    strb.clrBit = clrPos[BIT_W-1:0];
  end

  always_comb begin
    strb.rdSel = RD_NONE;
    if (rdEn) begin
      if (rdAddr == PLAT_ADDR) strb.rdSel = RD_PLAT;
      else if (isLarge(mode)) begin
        if (rdAddr == WORD0_ADDR)      strb.rdSel = RD_WORD0;
        else if (rdAddr == WORD1_ADDR) strb.rdSel = RD_WORD1;
      end else begin
        case (rdAddr)
          LANE_ADDR:                   strb.rdSel = RD_LANE3;
          LANE_ADDR + ADDR_W'(1):      strb.rdSel = RD_LANE2;
          LANE_ADDR + ADDR_W'(2):      strb.rdSel = RD_LANE1;
          LANE_ADDR + ADDR_W'(3):      strb.rdSel = RD_LANE0;
          default:                     strb.rdSel = RD_NONE;
        endcase
      end
    end
  end

  // R4: small chassis never routes an event into word 1
  assert_small_word0_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!isLarge(mode) && (strb.setEn || strb.clrEn)) |->
      ((!strb.setEn || !strb.setReg) && (!strb.clrEn || !strb.clrReg)));

  // R6: slot codes beyond six never produce an event
  assert_unmapped_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && 3'(setSlot) == 3'd7) |-> !strb.setEn);

  // R10: whole-word selects only occur in the large chassis
  assert_word_sel_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_WORD0 || strb.rdSel == RD_WORD1) |-> isLarge(mode));

endmodule

// File: rtl/nirq_datapath.sv
module nirq_datapath
  import nirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chassisE     mode,
  input  strobeT      strb,
  output logic [31:0] rdData,
  output logic        netIrq
);

  localparam int NUM_REGS = 2;
  localparam int FLAT_W   = NUM_REGS * STATUS_W;

  logic [FLAT_W-1:0] statusFlat, setVec, clrVec;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [STATUS_W-1:0] regQ, setMask, clrMask;
    assign setMask = (strb.setEn && strb.setReg == 1'(r)) ? (STATUS_W'(1) << strb.setBit) : '0;
    assign clrMask = (strb.clrEn && strb.clrReg == 1'(r)) ? (STATUS_W'(1) << strb.clrBit) : '0;
    always_ff @(posedge clk) begin
      if (!rstN) regQ <= '0;
      else       regQ <= (regQ & ~clrMask) | setMask;
    end
    assign statusFlat[r*STATUS_W +: STATUS_W] = regQ;
    assign setVec[r*STATUS_W +: STATUS_W]     = setMask;
    assign clrVec[r*STATUS_W +: STATUS_W]     = clrMask;
  end

  logic [STATUS_W-1:0] word0, word1;
  assign word0  = statusFlat[0 +: STATUS_W];
  assign word1  = statusFlat[STATUS_W +: STATUS_W];
  assign netIrq = (|word0) || (isLarge(mode) && (|word1));

  always_comb begin
    case (strb.rdSel)
      RD_LANE3: rdData = 32'(word0[31:24]);
      RD_LANE2: rdData = 32'(word0[23:16]);
      RD_LANE1: rdData = 32'(word0[15:8]);
      RD_LANE0: rdData = 32'(word0[7:0]);
      RD_WORD0: rdData = word0;
      RD_WORD1: rdData = word1;
      RD_PLAT:  rdData = 32'(platformCode(mode));
      default:  rdData = '0;
    endcase
  end

  // R2 / R7: a set strobe always lands, even against a clear
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((statusFlat & $past(setVec)) == $past(setVec)));

  // R3: a clear without a competing set empties the bit
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec != '0) && ((clrVec & setVec) == '0)) |=> ((statusFlat & $past(clrVec)) == '0));

  // R11: bits not named by an event hold, whatever is read
  assert_untouched_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((statusFlat ^ $past(statusFlat)) & ~$past(setVec | clrVec)) == '0));

  // R8: empty status never drives the interrupt
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlat == '0) |-> !netIrq);

endmodule

// File: rtl/nirq_aggregator.sv
module nirq_aggregator
  import nirq_pkg::*;
#(
  parameter int SLOT_W = 3,
  parameter int PORT_W = 5,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        chassisMode,
  input  logic              setValid,
  input  logic [SLOT_W-1:0] setSlot,
  input  logic [PORT_W-1:0] setPort,
  input  logic              clrValid,
  input  logic [SLOT_W-1:0] clrSlot,
  input  logic [PORT_W-1:0] clrPort,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              netIrq
);

  chassisE mode;
  strobeT  strb;
  assign mode = chassisE'(chassisMode);

  nirq_ctrl #(.SLOT_W(SLOT_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode),
    .setValid(setValid), .setSlot(setSlot), .setPort(setPort),
    .clrValid(clrValid), .clrSlot(clrSlot), .clrPort(clrPort),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  nirq_datapath u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb),
    .rdData(rdData), .netIrq(netIrq)
  );

endmodule

// File: tb/nirq_aggregator_tb.sv
module nirq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  chassisMode;
  logic        setValid, clrValid, rdEn;
  logic [2:0]  setSlot, clrSlot;
  logic [4:0]  setPort, clrPort;
  logic [17:0] rdAddr;
  logic [31:0] rdData;
  logic        netIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] m0, m1;

  always #5 clk = ~clk;

  nirq_aggregator u_dut (
    .clk(clk), .rstN(rstN), .chassisMode(chassisMode),
    .setValid(setValid), .setSlot(setSlot), .setPort(setPort),
    .clrValid(clrValid), .clrSlot(clrSlot), .clrPort(clrPort),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .netIrq(netIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Expected map from R4/R5/R6
  task automatic expMap(input int mode, input int slot, input int port,
                        output bit ok, output bit w1, output int pos);
    int base;
    ok = 1'b0; w1 = 1'b0; base = 0;
    if (mode >= 2) begin
      case (slot)
        0: begin ok = 1; w1 = 1; base = 0; end
        1: begin ok = 1; base = 24; end
        2: begin ok = 1; base = 16; end
        3: begin ok = 1; base = 28; end
        4: begin ok = 1; base = 20; end
        5: begin ok = 1; base = 8; end
        6: begin ok = 1; base = 0; end
        default: ok = 0;
      endcase
    end else begin
      case (slot)
        0: begin ok = 1; base = 16; end
        1: begin ok = 1; base = 24; end
        2: begin ok = (mode == 0); base = 0; end
        3: begin ok = (mode == 0); base = 8; end
        default: ok = 0;
      endcase
    end
    pos = base + port;
    if (pos > 31) ok = 0;
  endtask

  task automatic modelEvt(input int mode, input bit isSet, input int slot, input int port);
    bit ok, w1; int pos;
    expMap(mode, slot, port, ok, w1, pos);
    if (ok) begin
      if (isSet) begin if (w1) m1[pos] = 1'b1; else m0[pos] = 1'b1; end
      else       begin if (w1) m1[pos] = 1'b0; else m0[pos] = 1'b0; end
    end
  endtask

  // Drives at a falling edge; state is updated by the next rising edge.
  task automatic pulse(input bit doSet, input int sSlot, input int sPort,
                       input bit doClr, input int cSlot, input int cPort);
    @(negedge clk);
    setValid = doSet; setSlot = 3'(sSlot); setPort = 5'(sPort);
    clrValid = doClr; clrSlot = 3'(cSlot); clrPort = 5'(cPort);
    @(negedge clk);
    setValid = 1'b0; clrValid = 1'b0;
  endtask

  task automatic readAt(input logic [17:0] a, output logic [31:0] d);
    rdEn = 1'b1; rdAddr = a; #1;
    d = rdData;
    rdEn = 1'b0; #1;
  endtask

  task automatic readWords(input int mode, output logic [31:0] w0, output logic [31:0] w1);
    logic [31:0] b;
    if (mode >= 2) begin
      readAt(18'h10010, w0);
      readAt(18'h20010, w1);
    end else begin
      w0 = '0; w1 = '0;
      for (int i = 0; i < 4; i++) begin
        readAt(18'h20000 + 18'(i), b);
        w0 = w0 | (b << (8 * (3 - i)));
      end
    end
  endtask

  task automatic setMode(input int mode);
    @(negedge clk);
    chassisMode = 2'(mode);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1, d;
    rstN = 1'b0; chassisMode = 2'd2;
    setValid = 0; clrValid = 0; setSlot = 0; setPort = 0; clrSlot = 0; clrPort = 0;
    rdEn = 0; rdAddr = '0;
    m0 = '0; m1 = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1 irq after reset", 32'(netIrq), 32'd0);
    readWords(2, w0, w1);
    check("R1 word0 after reset", w0, 32'd0);
    check("R1 word1 after reset", w1, 32'd0);

    // Sweep: R2 R3 R4 R5 R6 R8 R9 R10
    for (int mode = 0; mode < 4; mode++) begin
      setMode(mode);
      for (int slot = 0; slot < 8; slot++) begin
        for (int port = 0; port < 32; port++) begin
          bit ok, wsel; int pos;
          expMap(mode, slot, port, ok, wsel, pos);
          modelEvt(mode, 1'b1, slot, port);
          pulse(1'b1, slot, port, 1'b0, 0, 0);
          readWords(mode, w0, w1);
          if (!ok)           check("R6 ignored event word0", w0, m0);
          else if (mode < 2) check("R4 R9 small map word0", w0, m0);
          else               check("R5 R10 large map word0", w0, m0);
          if (mode >= 2) check("R5 R10 large map word1", w1, m1);
          check("R8 irq after set", 32'(netIrq),
                32'((m0 != 0) || (mode >= 2 && m1 != 0)));
          modelEvt(mode, 1'b0, slot, port);
          pulse(1'b0, 0, 0, 1'b1, slot, port);
          readWords(mode, w0, w1);
          check("R3 cleared word0", w0, m0);
          if (mode >= 2) check("R3 cleared word1", w1, m1);
          check("R8 irq after clear", 32'(netIrq), 32'd0);
        end
      end
    end

    // Accumulate and read twice (R2, R11)
    setMode(2);
    pulse(1'b1, 1, 0, 1'b0, 0, 0);
    pulse(1'b1, 0, 3, 1'b0, 0, 0);
    readWords(2, w0, w1);
    check("R2 accumulate word0", w0, 32'h0100_0000);
    check("R2 accumulate word1", w1, 32'h0000_0008);
    @(negedge clk); @(negedge clk);
    readWords(2, w0, w1);
    check("R11 reread word0", w0, 32'h0100_0000);
    check("R11 reread word1", w1, 32'h0000_0008);

    // R7: set and clear of the same bit together
    pulse(1'b1, 1, 0, 1'b1, 1, 0);
    readWords(2, w0, w1);
    check("R7 set wins held bit", w0, 32'h0100_0000);
    pulse(1'b1, 2, 1, 1'b1, 2, 1);
    readWords(2, w0, w1);
    check("R7 set wins new bit", w0, 32'h0102_0000);
    // R2/R3: set and clear of different bits together
    pulse(1'b1, 5, 7, 1'b1, 2, 1);
    readWords(2, w0, w1);
    check("R3 concurrent clear other bit", w0, 32'h0100_8000);

    // R8: word 1 alone drives the line only in large modes
    pulse(1'b0, 0, 0, 1'b1, 1, 0);
    pulse(1'b0, 0, 0, 1'b1, 5, 7);
    check("R8 large irq from word1", 32'(netIrq), 32'd1);
    setMode(1);
    check("R8 small ignores word1", 32'(netIrq), 32'd0);
    setMode(3);
    check("R8 mode3 irq from word1", 32'(netIrq), 32'd1);
    readAt(18'h20010, d);
    check("R10 mode3 word1 read", d, 32'h0000_0008);

    // R10: cross-mode addresses read zero
    pulse(1'b1, 1, 7, 1'b0, 0, 0);
    readAt(18'h20000, d);
    check("R10 lane addr zero in large", d, 32'd0);
    setMode(0);
    readAt(18'h10010, d);
    check("R10 word addr zero in small", d, 32'd0);
    readAt(18'h20000, d);
    check("R9 lane3 after mode switch", d, 32'h0000_0080);

    // R12: platform codes, unknown address, rdEn low
    for (int mode = 0; mode < 4; mode++) begin
      setMode(mode);
      readAt(18'h30000, d);
      check("R12 platform code", d, (mode == 0) ? 32'h00 : (mode == 1) ? 32'h80 : 32'h60);
    end
    readAt(18'h12345, d);
    check("R12 unknown addr", d, 32'd0);
    rdEn = 1'b0; rdAddr = 18'h10010; #1;
    check("R12 rdEn low", rdData, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule